// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line programmable interrupt controller. Each cycle it takes the latched request vector, the mask and the mode settings. From these and its own in-service vector and rotation base it decides whether the interrupt output should be raised, and which line wins. Priority is not fixed. It is measured as the distance of a line from a rotation base, and the line at the base is the most urgent.

The block also owns the in-service register and the rotation base. An acknowledge strobe marks the winning line as in service, or rotates priority past it when auto-EOI is on. End-of-interrupt strobes retire a line, either the most urgent one in service or one named by the line operand, and can optionally rotate the base past it. A set-base strobe places the lowest priority on a chosen line. Special-mask mode and special fully nested mode change which in-service lines block a new request. The request latching logic and the byte-wide programming interface sit outside the block.

Top module: `irq_resolver`

## Requirements
- R1: The candidate vector is `req_i & ~mask_i`. When it is zero, `irq` is 0 and `win_line` is 0.
- R2: A line's rank is its offset `(line - base) mod 8` from the rotation base, and a smaller offset means higher priority. `win_line` is the candidate with the smallest offset. After reset the base is 0, so line 0 ranks highest.
- R3: `irq` is 1 only when the best candidate offset is strictly smaller than the offset of the most urgent blocking in-service line. With nothing blocking, any candidate raises `irq`. While `irq` is 0, `win_line` is 0.
- R4: With `smask_mode` = 1, in-service lines whose mask bit is 1 do not block requests.
- R5: With `nested_mode` = 1 in the master instance (parameter `IS_MASTER` = 1), in-service bit `CASCADE_LINE` (default 2) does not block requests.
- R6: An `ack` while `irq` = 1 and `auto_eoi` = 0 sets `isr[win_line]` at the next edge. An `ack` while `irq` = 0 changes nothing.
- R7: An `ack` while `irq` = 1 and `auto_eoi` = 1 leaves `isr` unchanged. If `rot_on_aeoi` = 1, the base becomes `(win_line + 1) mod 8`.
- R8: `eoi_any` clears the most urgent in-service bit, ranked over the full `isr` without masking. With `eoi_rotate` = 1 the base becomes that line + 1. When `isr` is empty, it has no effect.
- R9: `eoi_line` clears `isr[line_sel]`. With `eoi_rotate` = 1 the base becomes `(line_sel + 1) mod 8`.
- R10: `set_base` sets the base to `(line_sel + 1) mod 8`, which leaves `line_sel` as the lowest-priority line.
- R11: A synchronous reset (`rst` = 1 at an edge) clears `isr` and the base to zero.
- R12: Only one strobe acts per edge, with precedence `ack` > `eoi_any` > `eoi_line` > `set_base`. Lower-priority strobes asserted in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N | Latched request vector |
| mask_i | input | N | Mask vector, 1 = masked |
| smask_mode | input | 1 | Special-mask mode |
| nested_mode | input | 1 | Special fully nested mode |
| auto_eoi | input | 1 | Auto-EOI on acknowledge |
| rot_on_aeoi | input | 1 | Rotate the base on auto-EOI |
| ack | input | 1 | Acknowledge strobe |
| eoi_any | input | 1 | Non-specific EOI strobe |
| eoi_line | input | 1 | Specific EOI strobe |
| eoi_rotate | input | 1 | Rotating variant of both EOI strobes |
| set_base | input | 1 | Set-priority strobe |
| line_sel | input | log2(N) | Line operand for specific EOI and set-priority |
| irq | output | 1 | Interrupt output |
| win_line | output | log2(N) | Winning line number |
| isr | output | N | In-service vector |

## Verification
`irq` and `win_line` are combinational from the inputs and the registered state, so they are due in the same cycle as a change of inputs. `isr` and the rotation base move exactly one edge after a strobe, and the base shows up only through `win_line`. The bench applies inputs at the falling edge and samples the outputs 1 ns later. Its model updates its own state right after that sample, so each comparison reflects every strobe that was taken at the rising edge in between.

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N            = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0]         mask_i,
  input  logic                 smask_mode,
  input  logic                 nested_mode,
  input  logic                 auto_eoi,
  input  logic                 rot_on_aeoi,
  input  logic                 ack,
  input  logic                 eoi_any,
  input  logic                 eoi_line,
  input  logic                 eoi_rotate,
  input  logic                 set_base,
  input  logic [$clog2(N)-1:0] line_sel,
  output logic                 irq,
  output logic [$clog2(N)-1:0] win_line,
  output logic [N-1:0]         isr
);
  localparam int IW = $clog2(N);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_LINE;

  logic [N-1:0]  isr_q, cand, blk;
  logic [IW-1:0] base_q, top_line;
  logic [IW:0]   cand_p, cur_p, top_p;

  function automatic logic [IW:0] rank(input logic [N-1:0] v, input logic [IW-1:0] b);
    logic [IW-1:0] idx;
    rank = (IW+1)'(N);
    for (int k = N-1; k >= 0; k--) begin
      idx = IW'(k) + b;
      if (v[idx]) rank = (IW+1)'(k);
    end
  endfunction

  assign cand     = req_i & ~mask_i;
  assign blk      = isr_q & ~(smask_mode ? mask_i : '0)
                          & ~((IS_MASTER && nested_mode) ? CASC_BIT : '0);
  assign cand_p   = rank(cand, base_q);
  assign cur_p    = rank(blk, base_q);
  assign top_p    = rank(isr_q, base_q);
  assign top_line = top_p[IW-1:0] + base_q;
  assign irq      = cand_p < cur_p;
  assign win_line = irq ? cand_p[IW-1:0] + base_q : '0;
  assign isr      = isr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      base_q <= '0;
    end else if (ack) begin
      if (irq) begin
        if (!auto_eoi) isr_q[win_line] <= 1'b1;
        else if (rot_on_aeoi) base_q <= win_line + 1'b1;
      end
    end else if (eoi_any) begin
      if (!top_p[IW]) begin
        isr_q[top_line] <= 1'b0;
        if (eoi_rotate) base_q <= top_line + 1'b1;
      end
    end else if (eoi_line) begin
      isr_q[line_sel] <= 1'b0;
      if (eoi_rotate) base_q <= line_sel + 1'b1;
    end else if (set_base) begin
      base_q <= line_sel + 1'b1;
    end
  end

  // R1
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cand == '0) |-> (!irq && win_line == '0));
  // R2
  winner_valid_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> cand[win_line]);
  // R6
  ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irq && !auto_eoi) |=> isr[$past(win_line)]);
  // R7
  aeoi_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && auto_eoi) |=> isr == $past(isr));
  // R8
  eoi_any_one_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_any && !ack && isr != '0) |=> $countones(isr) == $countones($past(isr)) - 1);
  // R9
  eoi_line_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_line && !ack && !eoi_any) |=> !isr[$past(line_sel)]);
  // R12
  only_ack_sets_chk: assert property (@(posedge clk) disable iff (rst)
    !ack |=> (isr & ~$past(isr)) == '0);
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> isr == '0);
endmodule

// File: tb/irq_resolver_bench.sv
module irq_resolver_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       d_rst = 1'b1;
  logic [7:0] d_req = '0, d_mask = '0;
  logic       d_sm = 0, d_nm = 0, d_ae = 0, d_ra = 0;
  logic       d_ack = 0, d_ea = 0, d_el = 0, d_er = 0, d_sb = 0;
  logic [2:0] d_ln = '0;

  logic       s_rst = 1'b1;
  logic [7:0] s_req = '0, s_mask = '0;
  logic       s_sm = 0, s_nm = 0, s_ae = 0, s_ra = 0;
  logic       s_ack = 0, s_ea = 0, s_el = 0, s_er = 0, s_sb = 0;
  logic [2:0] s_ln = '0;

  logic       irq;
  logic [2:0] win_line;
  logic [7:0] isr;

  irq_resolver u_irq_resolver (
    .clk(clk), .rst(d_rst), .req_i(d_req), .mask_i(d_mask),
    .smask_mode(d_sm), .nested_mode(d_nm), .auto_eoi(d_ae), .rot_on_aeoi(d_ra),
    .ack(d_ack), .eoi_any(d_ea), .eoi_line(d_el), .eoi_rotate(d_er),
    .set_base(d_sb), .line_sel(d_ln), .irq(irq), .win_line(win_line), .isr(isr)
  );

  int runs = 0, fails = 0;
  logic [7:0] m_isr = '0;
  logic [2:0] m_base = '0;

  function automatic int rank(logic [7:0] v, logic [2:0] b);
    for (int k = 0; k < 8; k++) if (v[3'(k + b)]) return k;
    return 8;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [7:0] cand, blk;
    int cp, bp, tp;
    logic e_irq;
    logic [2:0] e_win, tl;
    @(negedge clk);
    d_rst = s_rst; d_req = s_req; d_mask = s_mask; d_sm = s_sm; d_nm = s_nm;
    d_ae = s_ae; d_ra = s_ra; d_ack = s_ack; d_ea = s_ea; d_el = s_el;
    d_er = s_er; d_sb = s_sb; d_ln = s_ln;
    #1;
    cand = d_req & ~d_mask;
    blk = m_isr;
    if (d_sm) blk = blk & ~d_mask;
    if (d_nm) blk[2] = 1'b0;
    cp = rank(cand, m_base);
    bp = rank(blk, m_base);
    e_irq = cp < bp;
    e_win = e_irq ? 3'(cp + m_base) : 3'd0;
    chk(tag, "irq", int'(irq), int'(e_irq));
    chk(tag, "win_line", int'(win_line), int'(e_win));
    chk(tag, "isr", int'(isr), int'(m_isr));
    if (d_rst) begin
      m_isr = '0; m_base = '0;
    end else if (d_ack) begin
      if (e_irq) begin
        if (!d_ae) m_isr[e_win] = 1'b1;
        else if (d_ra) m_base = e_win + 3'd1;
      end
    end else if (d_ea) begin
      tp = rank(m_isr, m_base);
      if (tp < 8) begin
        tl = 3'(tp + m_base);
        m_isr[tl] = 1'b0;
        if (d_er) m_base = tl + 3'd1;
      end
    end else if (d_el) begin
      m_isr[d_ln] = 1'b0;
      if (d_er) m_base = d_ln + 3'd1;
    end else if (d_sb) begin
      m_base = d_ln + 3'd1;
    end
  endtask

  task automatic quiet();
    s_ack = 0; s_ea = 0; s_el = 0; s_er = 0; s_sb = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    step("R11"); step("R11");
    s_rst = 0; step("R11");
    s_req = 8'hFF; s_mask = 8'hFF; step("R1");
    s_req = 8'h00; s_mask = 8'h00; step("R1");
    s_req = 8'h28; step("R2");
    s_req = 8'h08; s_ack = 1; step("R6");
    quiet(); s_req = 8'h10; step("R3");
    s_req = 8'h18; step("R3");
    s_req = 8'h04; step("R3");
    s_req = 8'h10; s_mask = 8'h08; s_sm = 1; step("R4");
    s_sm = 0; s_mask = 0; s_req = 8'h00; s_ack = 1; step("R6");
    quiet(); s_req = 8'h04; s_ack = 1; step("R6");
    quiet(); s_req = 8'h02; s_nm = 1; step("R5");
    s_nm = 0; step("R5");
    s_ea = 1; s_er = 0; step("R8");
    quiet(); s_ea = 1; s_er = 1; step("R8");
    quiet(); s_req = 8'h03; step("R8");
    s_ea = 1; step("R8");
    quiet(); step("R8");
    s_el = 1; s_ln = 3'd5; s_er = 1; step("R9");
    quiet(); s_req = 8'hC1; step("R9");
    s_sb = 1; s_ln = 3'd6; step("R10");
    quiet(); s_req = 8'h81; step("R10");
    s_req = 8'h20; s_ae = 1; s_ra = 1; s_ack = 1; step("R7");
    quiet(); s_req = 8'h21; step("R7");
    s_ae = 0; s_ra = 0; s_req = 8'h40; s_ack = 1; s_ea = 1; s_sb = 1; s_ln = 3'd0; step("R12");
    quiet(); s_el = 1; s_sb = 1; s_ln = 3'd6; step("R12");
    quiet(); s_req = 8'h80; step("R12");
    s_rst = 1; step("R11");
    s_rst = 0; s_req = 8'h81; step("R11");
    for (int i = 0; i < 3000; i++) begin
      s_rst = ($urandom % 200) == 0;
      s_req = 8'($urandom); s_mask = 8'($urandom) & 8'($urandom);
      s_sm = ($urandom % 4) == 0; s_nm = ($urandom % 4) == 0;
      s_ae = ($urandom % 5) == 0; s_ra = $urandom % 2;
      s_ack = ($urandom % 3) == 0; s_ea = ($urandom % 6) == 0;
      s_el = ($urandom % 6) == 0; s_er = $urandom % 2;
      s_sb = ($urandom % 8) == 0; s_ln = 3'($urandom);
      step("R3");
    end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule